// File: doc/BRIEF.md
# Two-Level Translation Lookaside Front End

This block turns 32-bit virtual addresses into physical addresses. Lookups go through a shared main TLB and two small micro TLBs, one serving instruction fetches and one serving data accesses. Every entry maps a region of one of four sizes. Two sizes are small pages of 4 KB and 16 KB, which a walker reaches through two table levels. Two sizes are large sections of 1 MB and 16 MB, which a walker reaches in one level.

A request presents a virtual address and a fetch/data flag for one cycle. The main TLB is searched first. If it misses, the micro TLB that matches the access type is searched. If both miss, the block raises a walk request toward an external table walker and holds it until the walker returns a fill: the physical base and the size code of the mapping. The fill completes the pending translation. It is also written into the main TLB and into the micro TLB of the access type that missed. Each array replaces its entries in round-robin order.

Top module: `xlat_front`

## Requirements
- R1: After reset, resp_valid_o and walk_req_o are 0 and every TLB entry is invalid, so the first request of any kind raises a walk.
- R2: A request is searched in the main TLB first. On a main hit, resp_valid_o is 1 in the cycle after the request, with resp_src_o = 2'b00 and the translated resp_paddr_o.
- R3: On a main miss, only the micro TLB of the access type is searched: the fetch micro TLB when req_fetch_i = 1 and the data micro TLB when it is 0. A micro hit answers in the cycle after the request with resp_src_o = 2'b01.
- R4: When both searched arrays miss, walk_req_o is 1 from the cycle after the request until the cycle after the fill. For that whole time walk_vaddr_o and walk_fetch_o hold the missing address and access type.
- R5: A fill (fill_valid_i = 1 while walk_req_o = 1) clears walk_req_o at the next edge. It gives resp_valid_o = 1 with resp_src_o = 2'b10 in the next cycle, and it writes the mapping into the main TLB and into the micro TLB of the pending access type.
- R6: Size code 00 = 4 KB, 01 = 16 KB, 10 = 1 MB, 11 = 16 MB. An entry matches when the virtual address agrees with its tag above the offset for that size. The physical address takes the entry's base above that offset and the virtual address's bits within it.
- R7: The main TLB holds 8 entries and each micro TLB holds 4. Each array writes fills into slots in round-robin order starting at slot 0 after reset.
- R8: A request made while walk_req_o = 1 is ignored and gets no response. A fill while walk_req_o = 0 is ignored and writes no entry.
- R9: When more than one entry of an array matches, the lowest-numbered slot supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request this cycle |
| req_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| req_vaddr_i | input | 32 | Virtual address to translate |
| resp_valid_o | output | 1 | Translation result valid |
| resp_src_o | output | 2 | Source of the result: 00 main, 01 micro, 10 walk fill |
| resp_paddr_o | output | 32 | Physical address |
| walk_req_o | output | 1 | Table walk requested, held until fill |
| walk_fetch_o | output | 1 | Access type of the pending walk |
| walk_vaddr_o | output | 32 | Virtual address of the pending walk |
| fill_valid_i | input | 1 | Walker returns a mapping |
| fill_pbase_i | input | 20 | Physical base, address bits 31:12 |
| fill_size_i | input | 2 | Size code of the returned mapping |

## Verification
Every result is a registered output. A main or micro hit appears one cycle after the request cycle, a walk request appears one cycle after the request that missed, and a fill's result appears one cycle after the fill cycle. The bench drives inputs on the falling edge. A behavioural model updates on each rising edge from the same inputs and predicts the registered outputs. The bench compares them with the design at every following falling edge, so each prediction is checked in exactly the cycle it falls due. Scenarios built for eviction, overlap, size boundaries and ignored stimulus tag the comparisons with the requirement under test.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;

  typedef enum logic [1:0] {
    SZ_4K  = 2'b00,
    SZ_16K = 2'b01,
    SZ_1M  = 2'b10,
    SZ_16M = 2'b11
  } pg_size_e;

  typedef enum logic [1:0] {
    SRC_MAIN  = 2'b00,
    SRC_MICRO = 2'b01,
    SRC_WALK  = 2'b10
  } xlat_src_e;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vtag;
    logic [VPN_W-1:0] pbase;
    pg_size_e         size;
  } xlat_entry_t;

  // page-number bits that lie inside the offset for a given size
  function automatic logic [VPN_W-1:0] size_mask(pg_size_e s);
    case (s)
      SZ_4K:   return VPN_W'(0);
      SZ_16K:  return VPN_W'(20'h00003);
      SZ_1M:   return VPN_W'(20'h000FF);
      default: return VPN_W'(20'h00FFF);
    endcase
  endfunction

  function automatic logic [VA_W-1:0] compose(logic [VPN_W-1:0] pbase, pg_size_e s,
                                              logic [VA_W-1:0] va);
    logic [VPN_W-1:0] m;
    m = size_mask(s);
    return {(pbase & ~m) | (va[VA_W-1:OFF_W] & m), va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/xlat_tlb_array.sv
module xlat_tlb_array
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [VPN_W-1:0] hit_pbase_o,
  output pg_size_e         hit_size_o,
  input  logic             wr_en_i,
  input  xlat_entry_t      wr_entry_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  xlat_entry_t         ent_q[ENTRIES];
  logic [IDX_W-1:0]    rr_q;
  logic [ENTRIES-1:0]  match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_q[g].valid &&
                      (((ent_q[g].vtag ^ lk_vpn_i) & ~size_mask(ent_q[g].size)) == '0);
  end

  // lowest slot wins: scan downward, last assignment sticks
  always_comb begin
    hit_o       = 1'b0;
    hit_pbase_o = '0;
    hit_size_o  = SZ_4K;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o       = 1'b1;
        hit_pbase_o = ent_q[i].pbase;
        hit_size_o  = ent_q[i].size;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
      rr_q <= '0;
    end else if (wr_en_i) begin
      ent_q[rr_q] <= wr_entry_i;
      rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_fetch_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             main_hit_i,
  input  logic [VPN_W-1:0] main_pbase_i,
  input  pg_size_e         main_size_i,
  input  logic             micro_hit_i,
  input  logic [VPN_W-1:0] micro_pbase_i,
  input  pg_size_e         micro_size_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_pbase_i,
  input  logic [1:0]       fill_size_i,
  output logic             resp_valid_o,
  output logic [1:0]       resp_src_o,
  output logic [VA_W-1:0]  resp_paddr_o,
  output logic             walk_req_o,
  output logic             walk_fetch_o,
  output logic [VA_W-1:0]  walk_vaddr_o,
  output logic             wr_main_o,
  output logic [1:0]       wr_micro_o,
  output xlat_entry_t      wr_entry_o
);
  logic            resp_valid_q, walk_q, walk_fetch_q;
  xlat_src_e       resp_src_q;
  logic [VA_W-1:0] resp_paddr_q, walk_va_q;
  logic            fill_take;
  pg_size_e        fill_size;

  assign fill_size = pg_size_e'(fill_size_i);
  assign fill_take = walk_q && fill_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_src_q   <= SRC_MAIN;
      resp_paddr_q <= '0;
      walk_q       <= 1'b0;
      walk_fetch_q <= 1'b0;
      walk_va_q    <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      if (walk_q) begin
        if (fill_valid_i) begin
          walk_q       <= 1'b0;
          resp_valid_q <= 1'b1;
          resp_src_q   <= SRC_WALK;
          resp_paddr_q <= compose(fill_pbase_i, fill_size, walk_va_q);
        end
      end else if (req_valid_i) begin
        if (main_hit_i) begin
          resp_valid_q <= 1'b1;
          resp_src_q   <= SRC_MAIN;
          resp_paddr_q <= compose(main_pbase_i, main_size_i, req_vaddr_i);
        end else if (micro_hit_i) begin
          resp_valid_q <= 1'b1;
          resp_src_q   <= SRC_MICRO;
          resp_paddr_q <= compose(micro_pbase_i, micro_size_i, req_vaddr_i);
        end else begin
          walk_q       <= 1'b1;
          walk_va_q    <= req_vaddr_i;
          walk_fetch_q <= req_fetch_i;
        end
      end
    end
  end

  always_comb begin
    wr_entry_o.valid = 1'b1;
    wr_entry_o.vtag  = walk_va_q[VA_W-1:OFF_W];
    wr_entry_o.pbase = fill_pbase_i;
    wr_entry_o.size  = fill_size;
  end

  assign wr_main_o     = fill_take;
  assign wr_micro_o[1] = fill_take && walk_fetch_q;
  assign wr_micro_o[0] = fill_take && !walk_fetch_q;

  assign resp_valid_o = resp_valid_q;
  assign resp_src_o   = resp_src_q;
  assign resp_paddr_o = resp_paddr_q;
  assign walk_req_o   = walk_q;
  assign walk_fetch_o = walk_fetch_q;
  assign walk_vaddr_o = walk_va_q;
endmodule

// File: rtl/xlat_front.sv
module xlat_front
  import xlat_pkg::*;
#(
  parameter int MAIN_ENTRIES  = 8,
  parameter int MICRO_ENTRIES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_fetch_i,
  input  logic [31:0] req_vaddr_i,
  output logic        resp_valid_o,
  output logic [1:0]  resp_src_o,
  output logic [31:0] resp_paddr_o,
  output logic        walk_req_o,
  output logic        walk_fetch_o,
  output logic [31:0] walk_vaddr_o,
  input  logic        fill_valid_i,
  input  logic [19:0] fill_pbase_i,
  input  logic [1:0]  fill_size_i
);
  localparam int N_MICRO = 2;  // index 0 data, 1 fetch

  logic             main_hit;
  logic [VPN_W-1:0] main_pbase;
  pg_size_e         main_size;
  logic             micro_hit[N_MICRO];
  logic [VPN_W-1:0] micro_pbase[N_MICRO];
  pg_size_e         micro_size[N_MICRO];
  logic             wr_main;
  logic [1:0]       wr_micro;
  xlat_entry_t      wr_entry;

  xlat_tlb_array #(.ENTRIES(MAIN_ENTRIES)) u_main (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_vpn_i    (req_vaddr_i[VA_W-1:OFF_W]),
    .hit_o       (main_hit),
    .hit_pbase_o (main_pbase),
    .hit_size_o  (main_size),
    .wr_en_i     (wr_main),
    .wr_entry_i  (wr_entry)
  );

  for (genvar g = 0; g < N_MICRO; g++) begin : g_micro
    xlat_tlb_array #(.ENTRIES(MICRO_ENTRIES)) u_arr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lk_vpn_i    (req_vaddr_i[VA_W-1:OFF_W]),
      .hit_o       (micro_hit[g]),
      .hit_pbase_o (micro_pbase[g]),
      .hit_size_o  (micro_size[g]),
      .wr_en_i     (wr_micro[g]),
      .wr_entry_i  (wr_entry)
    );
  end

  xlat_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_fetch_i   (req_fetch_i),
    .req_vaddr_i   (req_vaddr_i),
    .main_hit_i    (main_hit),
    .main_pbase_i  (main_pbase),
    .main_size_i   (main_size),
    .micro_hit_i   (micro_hit[req_fetch_i]),
    .micro_pbase_i (micro_pbase[req_fetch_i]),
    .micro_size_i  (micro_size[req_fetch_i]),
    .fill_valid_i  (fill_valid_i),
    .fill_pbase_i  (fill_pbase_i),
    .fill_size_i   (fill_size_i),
    .resp_valid_o  (resp_valid_o),
    .resp_src_o    (resp_src_o),
    .resp_paddr_o  (resp_paddr_o),
    .walk_req_o    (walk_req_o),
    .walk_fetch_o  (walk_fetch_o),
    .walk_vaddr_o  (walk_vaddr_o),
    .wr_main_o     (wr_main),
    .wr_micro_o    (wr_micro),
    .wr_entry_o    (wr_entry)
  );
endmodule

// File: rtl/xlat_front_chk.sv
module xlat_front_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [11:0] req_off_i,
  input logic        resp_valid_o,
  input logic [1:0]  resp_src_o,
  input logic [11:0] resp_off_o,
  input logic        walk_req_o,
  input logic        walk_fetch_o,
  input logic [31:0] walk_vaddr_o,
  input logic        fill_valid_i
);
  p_walk_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && !fill_valid_i |=> walk_req_o && $stable(walk_vaddr_o) && $stable(walk_fetch_o));

  p_no_resp_during_walk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resp_valid_o && walk_req_o));

  p_fill_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && fill_valid_i |=> !walk_req_o && resp_valid_o && resp_src_o == 2'b10);

  p_fill_offset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o && fill_valid_i |=> resp_off_o == $past(walk_vaddr_o[11:0]));

  p_hit_offset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_src_o != 2'b10 |-> resp_off_o == $past(req_off_i));

  p_req_answered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !walk_req_o |=> resp_valid_o != walk_req_o);

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o |=> !(resp_valid_o && resp_src_o != 2'b10));

  p_walk_from_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(walk_req_o) |-> $past(req_valid_i));
endmodule

bind xlat_front xlat_front_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_off_i    (req_vaddr_i[11:0]),
  .resp_valid_o (resp_valid_o),
  .resp_src_o   (resp_src_o),
  .resp_off_o   (resp_paddr_o[11:0]),
  .walk_req_o   (walk_req_o),
  .walk_fetch_o (walk_fetch_o),
  .walk_vaddr_o (walk_vaddr_o),
  .fill_valid_i (fill_valid_i)
);

// File: tb/xlat_front_bench.sv
`timescale 1ns/1ps
module xlat_front_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_fetch = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_pbase = '0;
  logic [1:0]  fill_size = '0;
  logic        resp_valid, walk_req, walk_fetch;
  logic [1:0]  resp_src;
  logic [31:0] resp_paddr, walk_vaddr;

  always #2.5 clk = ~clk;

  xlat_front u_xlat_front (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_fetch_i(req_fetch), .req_vaddr_i(req_vaddr),
    .resp_valid_o(resp_valid), .resp_src_o(resp_src), .resp_paddr_o(resp_paddr),
    .walk_req_o(walk_req), .walk_fetch_o(walk_fetch), .walk_vaddr_o(walk_vaddr),
    .fill_valid_i(fill_valid), .fill_pbase_i(fill_pbase), .fill_size_i(fill_size)
  );

  int    checks = 0, errors = 0, cycles = 0;
  bit    done = 0;
  string tag = "R1";

  // ---------------- reference model ----------------
  logic [19:0] mm_tag[8], mm_pb[8];
  logic [1:0]  mm_sz[8];
  bit          mm_v[8];
  logic [19:0] mu_tag[2][4], mu_pb[2][4];
  logic [1:0]  mu_sz[2][4];
  bit          mu_v[2][4];
  int          mm_rr, mu_rr[2];
  bit          e_walk, e_wf, e_rv;
  logic [31:0] e_wva, e_pa;
  logic [1:0]  e_src;

  function automatic int off_bits(logic [1:0] s);
    return (s == 2'd0) ? 12 : (s == 2'd1) ? 14 : (s == 2'd2) ? 20 : 24;
  endfunction
  function automatic bit covers(logic [19:0] t, logic [1:0] s, logic [31:0] va);
    return ((({t, 12'h000}) ^ va) >> off_bits(s)) == 0;
  endfunction
  function automatic logic [31:0] mk_pa(logic [19:0] pb, logic [1:0] s, logic [31:0] va);
    logic [31:0] m;
    m = (32'h1 << off_bits(s)) - 1;
    return ({pb, 12'h000} & ~m) | (va & m);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) mm_v[i] = 0;
      for (int k = 0; k < 2; k++) for (int i = 0; i < 4; i++) mu_v[k][i] = 0;
      mm_rr = 0; mu_rr[0] = 0; mu_rr[1] = 0;
      e_walk = 0; e_rv = 0; e_wf = 0; e_wva = '0; e_pa = '0; e_src = 0;
    end else begin
      bit found;
      e_rv = 0;
      found = 0;
      if (e_walk) begin
        if (fill_valid) begin
          int k;
          k = e_wf ? 1 : 0;
          mm_tag[mm_rr] = e_wva[31:12]; mm_pb[mm_rr] = fill_pbase;
          mm_sz[mm_rr] = fill_size; mm_v[mm_rr] = 1; mm_rr = (mm_rr + 1) % 8;
          mu_tag[k][mu_rr[k]] = e_wva[31:12]; mu_pb[k][mu_rr[k]] = fill_pbase;
          mu_sz[k][mu_rr[k]] = fill_size; mu_v[k][mu_rr[k]] = 1;
          mu_rr[k] = (mu_rr[k] + 1) % 4;
          e_walk = 0; e_rv = 1; e_src = 2'b10;
          e_pa = mk_pa(fill_pbase, fill_size, e_wva);
        end
      end else if (req_valid) begin
        int k;
        k = req_fetch ? 1 : 0;
        for (int i = 0; i < 8; i++)
          if (!found && mm_v[i] && covers(mm_tag[i], mm_sz[i], req_vaddr)) begin
            found = 1; e_rv = 1; e_src = 2'b00;
            e_pa = mk_pa(mm_pb[i], mm_sz[i], req_vaddr);
          end
        for (int i = 0; i < 4; i++)
          if (!found && mu_v[k][i] && covers(mu_tag[k][i], mu_sz[k][i], req_vaddr)) begin
            found = 1; e_rv = 1; e_src = 2'b01;
            e_pa = mk_pa(mu_pb[k][i], mu_sz[k][i], req_vaddr);
          end
        if (!found) begin
          e_walk = 1; e_wva = req_vaddr; e_wf = req_fetch;
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_ni) begin
        chk("reset resp_valid", 32'(resp_valid), 0);
        chk("reset walk_req", 32'(walk_req), 0);
      end else begin
        chk("resp_valid", 32'(resp_valid), 32'(e_rv));
        chk("walk_req", 32'(walk_req), 32'(e_walk));
        if (e_walk) begin
          chk("walk_vaddr", walk_vaddr, e_wva);
          chk("walk_fetch", 32'(walk_fetch), 32'(e_wf));
        end
        if (e_rv) begin
          chk("resp_src", 32'(resp_src), 32'(e_src));
          chk("resp_paddr", resp_paddr, e_pa);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  // one request; serve a walk if the design asks for one
  task automatic access(logic [31:0] va, bit f, logic [19:0] pb, logic [1:0] sz);
    @(negedge clk);
    req_valid = 1; req_fetch = f; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    if (walk_req) begin
      fill_valid = 1; fill_pbase = pb; fill_size = sz;
      @(negedge clk);
      fill_valid = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: empty after reset -> walk
    tag = "R1";
    access(32'h0001_2345, 0, 20'h80000, 2'b00);
    // R5 / R6 small pages
    tag = "R5";
    access(32'h0004_5678, 0, 20'h90004, 2'b01);
    // R2: main hits, other offsets in the same 16 KB page
    tag = "R2";
    access(32'h0001_2FFF, 0, 20'h0, 2'b00);
    access(32'h0004_7ABC, 1, 20'h0, 2'b00);
    // R6: sections and size boundaries
    tag = "R6";
    access(32'h0230_0ABC, 0, 20'hA0000, 2'b10);
    access(32'h023F_FFFF, 0, 20'h0, 2'b00);
    access(32'h0240_0000, 0, 20'hA1000, 2'b00);
    access(32'h0500_0010, 1, 20'hB5000, 2'b11);
    access(32'h05FF_0004, 0, 20'h0, 2'b00);
    access(32'h0004_8000, 0, 20'h91000, 2'b00);
    // R7 / R3: four fetch pages, then eight data pages evict them from main
    tag = "R7";
    for (int i = 0; i < 4; i++)
      access(32'h1000_0000 + 32'(i) * 32'h1000, 1, 20'hC0000 + 20'(i), 2'b00);
    for (int i = 0; i < 8; i++)
      access(32'h2000_0000 + 32'(i) * 32'h1000, 0, 20'hD0000 + 20'(i), 2'b00);
    tag = "R3";
    for (int i = 0; i < 4; i++)
      access(32'h1000_0010 + 32'(i) * 32'h1000, 1, 20'h0, 2'b00);
    access(32'h1000_0020, 0, 20'hE0000, 2'b00);  // data micro lacks it
    tag = "R7";
    access(32'h1000_4000, 1, 20'hE1000, 2'b00);  // evicts fetch micro slot 1
    access(32'h1000_1000, 1, 20'hE2000, 2'b00);
    // R8: requests during walk and fill while idle are ignored
    tag = "R8";
    @(negedge clk);
    req_valid = 1; req_fetch = 0; req_vaddr = 32'h3000_0000;
    @(negedge clk);
    req_vaddr = 32'h2000_0000;
    repeat (3) @(negedge clk);
    req_valid = 0; fill_valid = 1; fill_pbase = 20'hF0000; fill_size = 0;
    @(negedge clk);
    fill_valid = 0;
    @(negedge clk);
    fill_valid = 1; fill_pbase = 20'hF1000; fill_size = 2'b11;
    @(negedge clk);
    fill_valid = 0;
    access(32'h3100_0000, 0, 20'hF2000, 2'b00);
    // R9: overlapping entries, lowest slot wins
    tag = "R9";
    access(32'h0801_0000, 0, 20'h11000, 2'b00);
    access(32'h0802_0000, 0, 20'h12000, 2'b11);
    access(32'h0801_0123, 0, 20'h0, 2'b00);
    access(32'h0803_0456, 1, 20'h0, 2'b00);
    // mixed sweep
    tag = "R2";
    for (int i = 0; i < 60; i++) begin
      logic [31:0] va;
      va = {4'(i % 3), 8'h00, 4'(i % 5), 4'h0, 12'(i * 37)};
      access(va, bit'(i % 2), 20'h40000 + 20'(i), 2'(i % 4));
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule